// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write path to an embedded flash array. It watches bus write cycles and recognises the multi-write sequences that software uses to drive the array's erase/program engine. A sequence opens with a two-write unlock. When the last write of a sequence is accepted, the decoder emits one registered request pulse. The pulse carries a command kind, the address of that final write and its 16-bit data. The engine behind it does the actual work: read/reset, word program, block erase, chip erase, erase suspend and resume, protection set or read, and temporary unprotect.

Array commands and protection commands use two different unlock address pairs. A block erase does not close on its first confirm write. It opens a collection window, and each further confirm write names one more block and restarts the window. The erase request goes out only after the window has run a full period with no write. The window length is a count of clock cycles, derived from the clock frequency and a time in microseconds. A write that does not fit the sequence in progress drops the decoder back to idle without a request. While the engine reports busy, only read/reset, suspend and resume can still be issued.

Top module: `fcmd_decoder`

## Requirements
- R1: During reset and on leaving it, cmdValid, cmdKind, cmdAddr, cmdData and eraseWindow are all 0. A reset in the middle of a sequence discards the partial sequence.
- R2: Command offsets are matched on address bits 13..0 only, with bits 14 and up ignored. Only data bits 7..0 are compared against command codes.
- R3: Unlock (A8h to offset 1554h, then 54h to offset 2AA8h), then A0h to 1554h, then a fourth write issues kind 2 (program). That request carries the fourth write's full address and full 16-bit data.
- R4: From idle, a single write of F0h to any address issues kind 1 (reset). B0h issues kind 6 (suspend), and 30h issues kind 7 (resume). Unlock followed by F0h to 1554h also issues kind 1.
- R5: Unlock, 80h to 1554h, unlock again, then 30h to any address issues kind 3 (block mark) with that address. eraseWindow is high from the following cycle.
- R6: While eraseWindow is high, each further 30h write issues another kind 3 and restarts the window. Kind 4 (block erase) is issued exactly WIN_CYC = CLK_MHZ*WIN_US cycles after the last accepted block write. It carries zero address and zero data, and eraseWindow falls in that same cycle.
- R7: Any other write while eraseWindow is high abandons the erase. No request is issued then or afterwards, and eraseWindow falls.
- R8: The first five block-erase writes followed by 10h to 1554h issue kind 5 (chip erase).
- R9: Protection unlock is A8h to offset 2A54h, then 54h to offset 15A8h. It is followed by one of three endings. 90h to 2A54h issues kind 9 (read protection). C1h to 2A54h, then F0h, issues kind 10 (unprotect). C0h to 2A54h, then a write to an address with bits 1..0 equal to 2'b10, issues kind 8 (set protection) carrying that write's data; any other address issues nothing.
- R10: A write that does not match the next expected step returns the decoder to idle silently. The next write is then decoded as the start of a new sequence.
- R11: While engBusy is high, the final write of program, block erase confirm, chip erase and all protection commands issues nothing. Kinds 1, 6 and 7 still issue.
- R12: cmdValid is a one-cycle pulse per completed command. Whenever cmdValid is low, cmdKind, cmdAddr and cmdData are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe toward the flash range |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 16 | Write data |
| engBusy | input | 1 | Erase/program engine is busy |
| cmdValid | output | 1 | Request pulse |
| cmdKind | output | 4 | Request kind (encoding in requirements) |
| cmdAddr | output | ADDR_W | Address captured from the completing write |
| cmdData | output | 16 | Data captured from the completing write |
| eraseWindow | output | 1 | Block-erase collection window is open |

## Verification
Every request is registered. It appears in the cycle after the clock edge that samples the completing write, so the bench drives each write between edges and samples the outputs 1 ns after the following edge. The one exception is the block erase request. It is due exactly WIN_CYC edges after the last block write, so the bench counts idle edges from that write and expects the pulse on the counted edge, with eraseWindow still high on the edge before. Silent cases, such as mismatches, the busy gate and an abandoned window, are checked by sampling after each write. A follow-up write whose result differs if the decoder had not returned to idle confirms the state.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  // command offsets, matched on address bits 13..0
  localparam logic [13:0] OFS_ARR_A = 14'h1554;
  localparam logic [13:0] OFS_ARR_B = 14'h2AA8;
  localparam logic [13:0] OFS_PRT_A = 14'h2A54;
  localparam logic [13:0] OFS_PRT_B = 14'h15A8;

  // command codes, matched on data bits 7..0
  localparam logic [7:0] CODE_UNL1  = 8'hA8;
  localparam logic [7:0] CODE_UNL2  = 8'h54;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_CONF  = 8'h30;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_RST   = 8'hF0;
  localparam logic [7:0] CODE_SUSP  = 8'hB0;
  localparam logic [7:0] CODE_SETP  = 8'hC0;
  localparam logic [7:0] CODE_RDP   = 8'h90;
  localparam logic [7:0] CODE_UNP   = 8'hC1;

  typedef enum logic [3:0] {
    CK_NONE        = 4'd0,
    CK_RESET       = 4'd1,
    CK_PROGRAM     = 4'd2,
    CK_BLOCK_MARK  = 4'd3,
    CK_BLOCK_ERASE = 4'd4,
    CK_CHIP_ERASE  = 4'd5,
    CK_SUSPEND     = 4'd6,
    CK_RESUME      = 4'd7,
    CK_SET_PROT    = 4'd8,
    CK_READ_PROT   = 4'd9,
    CK_UNPROT      = 4'd10
  } cmdKind_e;

  // datapath -> control: decoded view of the current write and the timer
  typedef struct packed {
    logic       hitArrA;
    logic       hitArrB;
    logic       hitPrtA;
    logic       hitPrtB;
    logic       oddWord;
    logic [7:0] dByte;
    logic       winDone;
  } dpFlags_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     issue;
    cmdKind_e kind;
    logic     zeroPayload;
    logic     winLoad;
    logic     winRun;
  } ctrlStrobe_t;

endpackage

// File: rtl/fcmd_dpath.sv
module fcmd_dpath
  import fcmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int WIN_CYC = 24000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  ctrlStrobe_t       strobe,
  output dpFlags_t          flags,
  output logic              cmdValid,
  output cmdKind_e          cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [15:0]       cmdData
);

  localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] winCnt;

  always_comb begin
    flags.hitArrA = (wrAddr[13:0] == OFS_ARR_A);
    flags.hitArrB = (wrAddr[13:0] == OFS_ARR_B);
    flags.hitPrtA = (wrAddr[13:0] == OFS_PRT_A);
    flags.hitPrtB = (wrAddr[13:0] == OFS_PRT_B);
    flags.oddWord = (wrAddr[1:0] == 2'b10);
    flags.dByte   = wrData[7:0];
    flags.winDone = (winCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobe.winLoad) begin
      winCnt <= CNT_LOAD;
    end else if (strobe.winRun) begin
      winCnt <= winCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKind  <= CK_NONE;
      cmdAddr  <= '0;
      cmdData  <= '0;
    end else begin
      cmdValid <= strobe.issue;
      cmdKind  <= strobe.issue ? strobe.kind : CK_NONE;
      cmdAddr  <= (strobe.issue && !strobe.zeroPayload) ? wrAddr : '0;
      cmdData  <= (strobe.issue && !strobe.zeroPayload) ? wrData : '0;
    end
  end

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        engBusy,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strobe,
  output logic        inWindow
);

  typedef enum logic [3:0] {
    S_IDLE, S_ARR1, S_ARR2, S_PGM, S_ERS1, S_ERS2, S_ERS3,
    S_WIN, S_PRT1, S_PRT2, S_PSET, S_PUNP
  } state_e;

  state_e st, stNext;
  logic [7:0] d;
  logic canRun;

  assign d        = flags.dByte;
  assign canRun   = !engBusy;
  assign inWindow = (st == S_WIN);

  always_comb begin
    stNext = st;
    strobe = '0;
    if (st == S_WIN && !wrEn) begin
      if (flags.winDone) begin
        strobe.issue       = 1'b1;
        strobe.kind        = CK_BLOCK_ERASE;
        strobe.zeroPayload = 1'b1;
        stNext             = S_IDLE;
      end else begin
        strobe.winRun = 1'b1;
      end
    end else if (wrEn) begin
      stNext = S_IDLE;
      unique case (st)
        S_IDLE: begin
          if (d == CODE_UNL1 && flags.hitArrA)      stNext = S_ARR1;
          else if (d == CODE_UNL1 && flags.hitPrtA) stNext = S_PRT1;
          else if (d == CODE_RST)  begin strobe.issue = 1'b1; strobe.kind = CK_RESET;   end
          else if (d == CODE_SUSP) begin strobe.issue = 1'b1; strobe.kind = CK_SUSPEND; end
          else if (d == CODE_CONF) begin strobe.issue = 1'b1; strobe.kind = CK_RESUME;  end
        end
        S_ARR1: if (d == CODE_UNL2 && flags.hitArrB) stNext = S_ARR2;
        S_ARR2: begin
          if (flags.hitArrA) begin
            if (d == CODE_PROG)       stNext = S_PGM;
            else if (d == CODE_ERASE) stNext = S_ERS1;
            else if (d == CODE_RST) begin strobe.issue = 1'b1; strobe.kind = CK_RESET; end
          end
        end
        S_PGM: begin
          strobe.issue = canRun;
          strobe.kind  = CK_PROGRAM;
        end
        S_ERS1: if (d == CODE_UNL1 && flags.hitArrA) stNext = S_ERS2;
        S_ERS2: if (d == CODE_UNL2 && flags.hitArrB) stNext = S_ERS3;
        S_ERS3: begin
          if (d == CODE_CONF && canRun) begin
            strobe.issue   = 1'b1;
            strobe.kind    = CK_BLOCK_MARK;
            strobe.winLoad = 1'b1;
            stNext         = S_WIN;
          end else if (d == CODE_CHIP && flags.hitArrA) begin
            strobe.issue = canRun;
            strobe.kind  = CK_CHIP_ERASE;
          end
        end
        S_WIN: begin
          if (d == CODE_CONF) begin
            strobe.issue   = 1'b1;
            strobe.kind    = CK_BLOCK_MARK;
            strobe.winLoad = 1'b1;
            stNext         = S_WIN;
          end
        end
        S_PRT1: if (d == CODE_UNL2 && flags.hitPrtB) stNext = S_PRT2;
        S_PRT2: begin
          if (flags.hitPrtA) begin
            if (d == CODE_SETP)     stNext = S_PSET;
            else if (d == CODE_UNP) stNext = S_PUNP;
            else if (d == CODE_RDP) begin strobe.issue = canRun; strobe.kind = CK_READ_PROT; end
          end
        end
        S_PSET: begin
          strobe.issue = canRun && flags.oddWord;
          strobe.kind  = CK_SET_PROT;
        end
        S_PUNP: begin
          strobe.issue = canRun && (d == CODE_RST);
          strobe.kind  = CK_UNPROT;
        end
        default: stNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stNext;
  end

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int CLK_MHZ = 250,
  parameter int WIN_US  = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              engBusy,
  output logic              cmdValid,
  output logic [3:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [15:0]       cmdData,
  output logic              eraseWindow
);

  localparam int WIN_CYC = CLK_MHZ * WIN_US;

  dpFlags_t    flags;
  ctrlStrobe_t strobe;
  cmdKind_e    kindE;

  fcmd_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .engBusy  (engBusy),
    .flags    (flags),
    .strobe   (strobe),
    .inWindow (eraseWindow)
  );

  fcmd_dpath #(
    .ADDR_W  (ADDR_W),
    .WIN_CYC (WIN_CYC)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .flags    (flags),
    .cmdValid (cmdValid),
    .cmdKind  (kindE),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData)
  );

  assign cmdKind = kindE;

endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [15:0]       wrData,
  input logic              engBusy,
  input logic              cmdValid,
  input logic [3:0]        cmdKind,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [15:0]       cmdData,
  input logic              eraseWindow
);

  // R12
  valid_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdKind != 4'd0);

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmdKind == 4'd0 && cmdAddr == '0 && cmdData == '0));

  // R4
  write_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind != 4'd4) |-> $past(wrEn));

  // R6
  erase_after_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 4'd4) |-> ($past(eraseWindow) && !$past(wrEn) && !eraseWindow));

  // R5
  window_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseWindow) |-> (cmdValid && cmdKind == 4'd3));

  // R3
  prog_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 4'd2) |-> (cmdAddr == $past(wrAddr) && cmdData == $past(wrData)));

  // R11
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdKind == 4'd2 || cmdKind == 4'd5 || cmdKind == 4'd8 ||
                  cmdKind == 4'd9 || cmdKind == 4'd10)) |-> !$past(engBusy));

endmodule

bind fcmd_decoder fcmd_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .engBusy     (engBusy),
  .cmdValid    (cmdValid),
  .cmdKind     (cmdKind),
  .cmdAddr     (cmdAddr),
  .cmdData     (cmdData),
  .eraseWindow (eraseWindow)
);

// File: tb/test_fcmd_decoder.sv
`timescale 1ns/1ps
module test_fcmd_decoder;

  localparam int AW  = 18;
  localparam int WIN = 250 * 96;
  localparam int NV  = 43;

  // vector: {req[3:0], busy, addr[17:0], data[15:0], expKind[3:0]}
  localparam logic [42:0] VEC [NV] = '{
    {4'd4,  1'b0, 18'h3FFFF, 16'h00F0, 4'd1},  // R4 single reset
    {4'd4,  1'b0, 18'h12345, 16'h00B0, 4'd6},  // R4 suspend
    {4'd4,  1'b0, 18'h00100, 16'h0030, 4'd7},  // R4 resume
    {4'd2,  1'b0, 18'h35554, 16'hFFA8, 4'd0},  // R2 high bits ignored
    {4'd2,  1'b0, 18'h06AA8, 16'h1254, 4'd0},  // R2
    {4'd3,  1'b0, 18'h01554, 16'h00A0, 4'd0},  // R3
    {4'd3,  1'b0, 18'h2468A, 16'hBEEF, 4'd2},  // R3 program issued
    {4'd10, 1'b0, 18'h01554, 16'h00A8, 4'd0},  // R10
    {4'd10, 1'b0, 18'h02AA9, 16'h0054, 4'd0},  // R10 wrong offset
    {4'd10, 1'b0, 18'h01554, 16'h00A0, 4'd0},  // R10 idle, no effect
    {4'd10, 1'b0, 18'h01000, 16'h1234, 4'd0},  // R10 no program
    {4'd4,  1'b0, 18'h01554, 16'h00A8, 4'd0},  // R4 unlock reset
    {4'd4,  1'b0, 18'h02AA8, 16'h0054, 4'd0},  // R4
    {4'd4,  1'b0, 18'h01554, 16'h00F0, 4'd1},  // R4
    {4'd8,  1'b0, 18'h01554, 16'h00A8, 4'd0},  // R8 chip erase
    {4'd8,  1'b0, 18'h02AA8, 16'h0054, 4'd0},  // R8
    {4'd8,  1'b0, 18'h01554, 16'h0080, 4'd0},  // R8
    {4'd8,  1'b0, 18'h01554, 16'h00A8, 4'd0},  // R8
    {4'd8,  1'b0, 18'h02AA8, 16'h0054, 4'd0},  // R8
    {4'd8,  1'b0, 18'h01554, 16'h0010, 4'd5},  // R8
    {4'd9,  1'b0, 18'h02A54, 16'h00A8, 4'd0},  // R9 set prot, bad address
    {4'd9,  1'b0, 18'h015A8, 16'h0054, 4'd0},  // R9
    {4'd9,  1'b0, 18'h02A54, 16'h00C0, 4'd0},  // R9
    {4'd9,  1'b0, 18'h00004, 16'hFF7E, 4'd0},  // R9 not odd word
    {4'd9,  1'b0, 18'h02A54, 16'h00A8, 4'd0},  // R9 set prot
    {4'd9,  1'b0, 18'h015A8, 16'h0054, 4'd0},  // R9
    {4'd9,  1'b0, 18'h02A54, 16'h00C0, 4'd0},  // R9
    {4'd9,  1'b0, 18'h00006, 16'hFF7E, 4'd8},  // R9
    {4'd9,  1'b0, 18'h02A54, 16'h00A8, 4'd0},  // R9 read prot
    {4'd9,  1'b0, 18'h015A8, 16'h0054, 4'd0},  // R9
    {4'd9,  1'b0, 18'h02A54, 16'h0090, 4'd9},  // R9
    {4'd9,  1'b0, 18'h02A54, 16'h00A8, 4'd0},  // R9 unprotect
    {4'd9,  1'b0, 18'h015A8, 16'h0054, 4'd0},  // R9
    {4'd9,  1'b0, 18'h02A54, 16'h00C1, 4'd0},  // R9
    {4'd9,  1'b0, 18'h00000, 16'h00F0, 4'd10}, // R9
    {4'd11, 1'b1, 18'h01554, 16'h00A8, 4'd0},  // R11 busy program
    {4'd11, 1'b1, 18'h02AA8, 16'h0054, 4'd0},  // R11
    {4'd11, 1'b1, 18'h01554, 16'h00A0, 4'd0},  // R11
    {4'd11, 1'b1, 18'h00010, 16'hBEEF, 4'd0},  // R11 gated
    {4'd11, 1'b1, 18'h00022, 16'h00F0, 4'd1},  // R11 reset passes
    {4'd11, 1'b1, 18'h00000, 16'h00B0, 4'd6},  // R11 suspend passes
    {4'd10, 1'b0, 18'h01554, 16'h00A8, 4'd0},  // R10
    {4'd10, 1'b0, 18'h00000, 16'h00F0, 4'd0}   // R10 mismatch in unlock
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [15:0]   wrData = '0;
  logic          engBusy = 1'b0;
  logic          cmdValid;
  logic [3:0]    cmdKind;
  logic [AW-1:0] cmdAddr;
  logic [15:0]   cmdData;
  logic          eraseWindow;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  fcmd_decoder i_fcmd_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .engBusy(engBusy), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .eraseWindow(eraseWindow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one write; outputs sampled 1 ns after the edge that takes it
  task automatic doWrite(input logic [AW-1:0] a, input logic [15:0] dt, input logic busy);
    wrEn = 1'b1; wrAddr = a; wrData = dt; engBusy = busy;
    @(posedge clk); #1;
    wrEn = 1'b0; engBusy = 1'b0;
  endtask

  task automatic expectNone(input string tag);
    chk({tag, " valid"}, {31'd0, cmdValid}, 32'd0);
  endtask

  task automatic eraseUnlock();
    doWrite(18'h01554, 16'h00A8, 1'b0);
    doWrite(18'h02AA8, 16'h0054, 1'b0);
    doWrite(18'h01554, 16'h0080, 1'b0);
    doWrite(18'h01554, 16'h00A8, 1'b0);
    doWrite(18'h02AA8, 16'h0054, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 valid", {31'd0, cmdValid}, 32'd0);
    chk("R1 kind", {28'd0, cmdKind}, 32'd0);
    chk("R1 addr", {14'd0, cmdAddr}, 32'd0);
    chk("R1 data", {16'd0, cmdData}, 32'd0);
    chk("R1 window", {31'd0, eraseWindow}, 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      automatic logic [3:0]    rq = VEC[i][42:39];
      automatic logic          bz = VEC[i][38];
      automatic logic [AW-1:0] ad = VEC[i][37:20];
      automatic logic [15:0]   dt = VEC[i][19:4];
      automatic logic [3:0]    ek = VEC[i][3:0];
      doWrite(ad, dt, bz);
      chk($sformatf("R%0d vec%0d valid", rq, i), {31'd0, cmdValid}, {31'd0, ek != 4'd0});
      chk($sformatf("R%0d vec%0d kind", rq, i), {28'd0, cmdKind}, {28'd0, ek});
      chk($sformatf("R%0d vec%0d addr", rq, i), {14'd0, cmdAddr}, (ek != 4'd0) ? {14'd0, ad} : 32'd0);
      chk($sformatf("R%0d vec%0d data", rq, i), {16'd0, cmdData}, (ek != 4'd0) ? {16'd0, dt} : 32'd0);
      chk($sformatf("R%0d vec%0d window", rq, i), {31'd0, eraseWindow}, 32'd0);
    end

    // R1 reset mid-sequence discards it
    doWrite(18'h01554, 16'h00A8, 1'b0);
    doWrite(18'h02AA8, 16'h0054, 1'b0);
    rstN = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    doWrite(18'h01554, 16'h00A0, 1'b0);
    doWrite(18'h00040, 16'h5555, 1'b0);
    expectNone("R1 after mid reset");

    // R11 busy block-erase confirm
    eraseUnlock();
    doWrite(18'h14000, 16'h0030, 1'b1);
    expectNone("R11 busy confirm");
    chk("R11 window closed", {31'd0, eraseWindow}, 32'd0);

    // R5 first block
    eraseUnlock();
    doWrite(18'h14000, 16'h0030, 1'b0);
    chk("R5 kind", {28'd0, cmdKind}, 32'd3);
    chk("R5 addr", {14'd0, cmdAddr}, 32'h14000);
    chk("R5 window", {31'd0, eraseWindow}, 32'd1);
    repeat (100) @(posedge clk);
    #1;
    chk("R6 window held", {31'd0, eraseWindow}, 32'd1);
    // R6 second block restarts window
    doWrite(18'h20000, 16'h0030, 1'b0);
    chk("R6 mark kind", {28'd0, cmdKind}, 32'd3);
    chk("R6 mark addr", {14'd0, cmdAddr}, 32'h20000);
    begin
      int n = 0;
      int early = 0;
      int winBefore = 0;
      while (n < WIN + 10) begin
        @(posedge clk); #1;
        n++;
        if (cmdValid) break;
        if (n == WIN - 1) winBefore = eraseWindow;
        if (!eraseWindow) early++;
      end
      chk("R6 erase delay", n, WIN);
      chk("R6 window before erase", winBefore, 1);
      chk("R6 no early close", early, 0);
      chk("R6 erase kind", {28'd0, cmdKind}, 32'd4);
      chk("R6 erase addr", {14'd0, cmdAddr}, 32'd0);
      chk("R6 erase data", {16'd0, cmdData}, 32'd0);
      chk("R6 window fell", {31'd0, eraseWindow}, 32'd0);
    end
    @(posedge clk); #1;
    chk("R12 one-cycle pulse", {31'd0, cmdValid}, 32'd0);

    // R7 abandon window
    eraseUnlock();
    doWrite(18'h08000, 16'h0030, 1'b0);
    chk("R7 mark", {28'd0, cmdKind}, 32'd3);
    doWrite(18'h00000, 16'h00B0, 1'b0);
    expectNone("R7 stray write");
    chk("R7 window dropped", {31'd0, eraseWindow}, 32'd0);
    begin
      int seen = 0;
      for (int k = 0; k < WIN + 5; k++) begin
        @(posedge clk); #1;
        if (cmdValid) seen++;
      end
      chk("R7 no erase", seen, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule